// File: doc/BRIEF.md
# Shared-Pin Serial I/O Expander Core

This block is the digital I/O half of a serially programmed expander. A frame decoder in front of it presents a 12-bit data word with one strobe per command. The block keeps a direction word and an output latch for twelve general-purpose pins. On request it captures a snapshot of the twelve pin levels into a capture word. The serial shifter behind it sends that word out during the next transaction.

The eight upper pins (D4..D11) double as analog converter outputs. Each analog channel has its own high-impedance flag. Pin D11 pairs with converter channel 5, D10 with channel 6, and so on down to D4, which pairs with channel 12. The block decides, pin by pin, whether its digital driver may be enabled. If software enables a digital output on a shared pin while the paired converter channel is still driving, the block holds the digital driver off and raises a contention flag for that channel. The tristate pads and the analog path are outside this block.

Top module: `ioexp_shared_pins`

## Requirements
- R1: While `rst` is high at a rising edge, every register clears: `pin_oe`, `pin_out`, `cap_word` and `contention` are all zero after that edge, so every pin starts as a high-impedance input.
- R2: A `dir_wr` strobe loads `wr_data` into the direction word, with bit j controlling pin Dj (1 = output, 0 = high-impedance input). For an uncontended pin, `pin_oe[j]` follows the new value from the same clock edge.
- R3: An `out_wr` strobe loads `wr_data` into the output latch, with bit j going to pin Dj. `pin_out` shows the new value from the same edge.
- R4: The direction word and the output latch keep their contents on every edge that has no strobe for them.
- R5: A `cap_req` strobe at an edge stores `pin_in[j]` into `cap_word[j]` for each pin that is not driving at that edge. `cap_word` then holds its value until the next `cap_req`.
- R6: For a pin that is driving when `cap_req` arrives, the capture records the output latch bit instead of `pin_in`.
- R7: `dac_hiz[k]` belongs to converter channel k+5 and to pin D(11-k). It affects only that pin.
- R8: When the direction bit of a shared pin is 1 and its paired `dac_hiz` bit is 0, `contention[k]` is 1 and `pin_oe` for that pin is 0 after the edge. Both return to the plain direction behaviour at the first edge that sees the `dac_hiz` bit high.
- R9: Changes on `dac_hiz` never alter the direction word. A suppressed output pin drives again once its converter channel goes high-impedance, with no rewrite of the direction word.
- R10: Pins D0..D3 ignore `dac_hiz` completely.
- R11: A shared pin whose driver is suppressed by contention is captured from `pin_in`.
- R12: When `cap_req` and `out_wr` share an edge, the capture uses the output latch and enables as they stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_wr | input | 1 | Strobe: load direction word from `wr_data` |
| out_wr | input | 1 | Strobe: load output latch from `wr_data` |
| cap_req | input | 1 | Strobe: capture pin levels into `cap_word` |
| wr_data | input | 12 | Data word from the frame decoder, bit j for pin Dj |
| pin_in | input | 12 | Levels sensed at the pads, bit j for pin Dj |
| dac_hiz | input | 8 | Converter high-impedance flags, bit k for channel k+5 |
| pin_oe | output | 12 | Digital driver enable, bit j for pin Dj |
| pin_out | output | 12 | Digital driver value, bit j for pin Dj |
| cap_word | output | 12 | Captured pin snapshot for serial readback |
| contention | output | 8 | Contention flag, bit k for channel k+5 / pin D(11-k) |

## Verification
Every result of this block is due at the same rising edge that samples its cause. A strobe or a `dac_hiz` change seen at edge E is visible on `pin_oe`, `pin_out`, `contention` or `cap_word` just after E. The bench drives inputs on falling edges, waits for the next rising edge, and reads all four outputs 1 ns later, before any input moves again. Each stimulus row thus is matched to exactly the edge that consumed it. Hold behaviour is checked on rows that carry no strobe. The simultaneous capture-and-write row checks that the capture took pre-edge state.

// File: rtl/ioexp_pkg.sv
package ioexp_pkg;

  localparam int DEF_PINS   = 12;
  localparam int DEF_SHARED = 8;

  // Source a captured bit comes from.
  typedef enum logic {
    SRC_PAD   = 1'b0,
    SRC_LATCH = 1'b1
  } cap_src_e;

  // Converter slot paired with a shared pin: the top pin pairs with slot 0.
  function automatic int dac_slot(input int pin, input int npins);
    return npins - 1 - pin;
  endfunction

endpackage

// File: rtl/ioexp_cfg_regs.sv
module ioexp_cfg_regs #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dir_wr,
  input  logic         out_wr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] dir_nxt,
  output logic [W-1:0] out_q
);

  logic [W-1:0] out_nxt;

  always_comb begin
    dir_nxt = dir_wr ? wr_data : dir_q;
    out_nxt = out_wr ? wr_data : out_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      dir_q <= dir_nxt;
      out_q <= out_nxt;
    end
  end

endmodule

// File: rtl/ioexp_pin_arbiter.sv
module ioexp_pin_arbiter #(
  parameter int N_PINS   = 12,
  parameter int N_SHARED = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_PINS-1:0]   dir_nxt,
  input  logic [N_SHARED-1:0] dac_hiz,
  output logic [N_PINS-1:0]   pin_oe,
  output logic [N_SHARED-1:0] contention
);
  import ioexp_pkg::*;

  localparam int N_DED = N_PINS - N_SHARED;

  for (genvar j = 0; j < N_PINS; j++) begin : g_pin
    if (j < N_DED) begin : g_dedicated
      always_ff @(posedge clk) begin
        if (rst) pin_oe[j] <= 1'b0;
        else     pin_oe[j] <= dir_nxt[j];
      end
    end else begin : g_shared
      localparam int K = dac_slot(j, N_PINS);
      logic analog_free;
      logic blocked;
      always_comb begin
        analog_free = dac_hiz[K];
        blocked     = dir_nxt[j] & ~analog_free;
      end
      always_ff @(posedge clk) begin
        if (rst) begin
          pin_oe[j]     <= 1'b0;
          contention[K] <= 1'b0;
        end else begin
          pin_oe[j]     <= dir_nxt[j] & analog_free;
          contention[K] <= blocked;
        end
      end
    end
  end

endmodule

// File: rtl/ioexp_capture.sv
module ioexp_capture #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_req,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] drv_en,
  input  logic [W-1:0] drv_val,
  output logic [W-1:0] cap_word
);
  import ioexp_pkg::*;

  logic [W-1:0] sensed;

  for (genvar j = 0; j < W; j++) begin : g_bit
    cap_src_e src;
    always_comb begin
      src       = drv_en[j] ? SRC_LATCH : SRC_PAD;
      sensed[j] = (src == SRC_LATCH) ? drv_val[j] : pin_in[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          cap_word <= '0;
    else if (cap_req) cap_word <= sensed;
  end

endmodule

// File: rtl/ioexp_shared_pins.sv
module ioexp_shared_pins #(
  parameter int N_PINS   = ioexp_pkg::DEF_PINS,
  parameter int N_SHARED = ioexp_pkg::DEF_SHARED
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dir_wr,
  input  logic                out_wr,
  input  logic                cap_req,
  input  logic [N_PINS-1:0]   wr_data,
  input  logic [N_PINS-1:0]   pin_in,
  input  logic [N_SHARED-1:0] dac_hiz,
  output logic [N_PINS-1:0]   pin_oe,
  output logic [N_PINS-1:0]   pin_out,
  output logic [N_PINS-1:0]   cap_word,
  output logic [N_SHARED-1:0] contention
);

  logic [N_PINS-1:0] dir_q;
  logic [N_PINS-1:0] dir_nxt;
  logic [N_PINS-1:0] out_q;
  logic              unused_dir;

  assign unused_dir = ^dir_q;

  ioexp_cfg_regs #(.W(N_PINS)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .dir_wr  (dir_wr),
    .out_wr  (out_wr),
    .wr_data (wr_data),
    .dir_q   (dir_q),
    .dir_nxt (dir_nxt),
    .out_q   (out_q)
  );

  ioexp_pin_arbiter #(.N_PINS(N_PINS), .N_SHARED(N_SHARED)) u_arb (
    .clk        (clk),
    .rst        (rst),
    .dir_nxt    (dir_nxt),
    .dac_hiz    (dac_hiz),
    .pin_oe     (pin_oe),
    .contention (contention)
  );

  ioexp_capture #(.W(N_PINS)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .cap_req  (cap_req),
    .pin_in   (pin_in),
    .drv_en   (pin_oe),
    .drv_val  (out_q),
    .cap_word (cap_word)
  );

  assign pin_out = out_q;

endmodule

// File: rtl/ioexp_shared_pins_sva.sv
module ioexp_shared_pins_sva #(
  parameter int N_PINS   = 12,
  parameter int N_SHARED = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                dir_wr,
  input logic                out_wr,
  input logic                cap_req,
  input logic [N_PINS-1:0]   wr_data,
  input logic [N_SHARED-1:0] dac_hiz,
  input logic [N_PINS-1:0]   pin_oe,
  input logic [N_PINS-1:0]   pin_out,
  input logic [N_PINS-1:0]   cap_word,
  input logic [N_SHARED-1:0] contention
);
  localparam int N_DED = N_PINS - N_SHARED;

  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst_d |-> (pin_oe == '0 && pin_out == '0 && cap_word == '0 && contention == '0));

  p_dir_load_r2: assert property (@(posedge clk) disable iff (rst)
    dir_wr |=> pin_oe[N_DED-1:0] == $past(wr_data[N_DED-1:0]));

  p_out_load_r3: assert property (@(posedge clk) disable iff (rst)
    out_wr |=> pin_out == $past(wr_data));

  p_out_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !out_wr |=> $stable(pin_out));

  p_cap_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !cap_req |=> $stable(cap_word));

  for (genvar k = 0; k < N_SHARED; k++) begin : g_ch
    p_oe_needs_hiz_r7: assert property (@(posedge clk) disable iff (rst)
      pin_oe[N_PINS-1-k] |-> $past(dac_hiz[k]));

    p_block_driver_r8: assert property (@(posedge clk) disable iff (rst)
      contention[k] |-> !pin_oe[N_PINS-1-k]);

    p_flag_cause_r8: assert property (@(posedge clk) disable iff (rst)
      contention[k] |-> !$past(dac_hiz[k]));
  end

endmodule

bind ioexp_shared_pins ioexp_shared_pins_sva #(.N_PINS(N_PINS), .N_SHARED(N_SHARED)) u_sva (
  .clk        (clk),
  .rst        (rst),
  .dir_wr     (dir_wr),
  .out_wr     (out_wr),
  .cap_req    (cap_req),
  .wr_data    (wr_data),
  .dac_hiz    (dac_hiz),
  .pin_oe     (pin_oe),
  .pin_out    (pin_out),
  .cap_word   (cap_word),
  .contention (contention)
);

// File: tb/ioexp_shared_pins_tb.sv
`timescale 1ns/1ps
module ioexp_shared_pins_tb;

  typedef struct packed {
    logic        dw;
    logic        ow;
    logic        cq;
    logic [11:0] data;
    logic [11:0] pins;
    logic [7:0]  hiz;
    logic [11:0] e_oe;
    logic [11:0] e_out;
    logic [11:0] e_cap;
    logic [7:0]  e_cont;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,12'h00F,12'h000,8'hFF,12'h00F,12'h000,12'h000,8'h00}, // R2 dir low nibble
    '{1'b0,1'b1,1'b0,12'hA5A,12'h000,8'hFF,12'h00F,12'hA5A,12'h000,8'h00}, // R3 latch load
    '{1'b0,1'b0,1'b1,12'h000,12'h3C3,8'hFF,12'h00F,12'hA5A,12'h3CA,8'h00}, // R5 R6 capture mix
    '{1'b0,1'b0,1'b0,12'hFFF,12'hFFF,8'hFF,12'h00F,12'hA5A,12'h3CA,8'h00}, // R4 R5 hold
    '{1'b1,1'b0,1'b0,12'hF00,12'hFFF,8'hFF,12'hF00,12'hA5A,12'h3CA,8'h00}, // R2 upper pins
    '{1'b0,1'b0,1'b0,12'h000,12'h000,8'hFE,12'h700,12'hA5A,12'h3CA,8'h01}, // R8 ch5 vs D11
    '{1'b0,1'b0,1'b0,12'h000,12'h000,8'h7F,12'hF00,12'hA5A,12'h3CA,8'h00}, // R7 R9 ch12 only D4
    '{1'b0,1'b0,1'b0,12'h000,12'h000,8'hF7,12'hE00,12'hA5A,12'h3CA,8'h08}, // R7 ch8 vs D8
    '{1'b0,1'b0,1'b1,12'h000,12'h155,8'hF7,12'hE00,12'hA5A,12'hB55,8'h08}, // R11 blocked pin read
    '{1'b1,1'b0,1'b0,12'h00F,12'h000,8'h00,12'h00F,12'hA5A,12'hB55,8'h00}, // R10 dedicated
    '{1'b0,1'b1,1'b1,12'h0F0,12'hFFF,8'h00,12'h00F,12'h0F0,12'hFFA,8'h00}, // R12 pre-edge cap
    '{1'b1,1'b0,1'b0,12'hFFF,12'h000,8'h00,12'h00F,12'h0F0,12'hFFA,8'hFF}, // R8 all blocked
    '{1'b0,1'b0,1'b0,12'h000,12'h000,8'hFF,12'hFFF,12'h0F0,12'hFFA,8'h00}  // R9 release
  };
  string vec_req [NV] = '{"R2","R3","R5/R6","R4/R5","R2","R8","R7/R9","R7","R11",
                          "R10","R12","R8","R9"};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dir_wr = 1'b0, out_wr = 1'b0, cap_req = 1'b0;
  logic [11:0] wr_data = '0, pin_in = '0;
  logic [7:0]  dac_hiz = 8'hFF;
  logic [11:0] pin_oe, pin_out, cap_word;
  logic [7:0]  contention;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ioexp_shared_pins u_dut (
    .clk(clk), .rst(rst), .dir_wr(dir_wr), .out_wr(out_wr), .cap_req(cap_req),
    .wr_data(wr_data), .pin_in(pin_in), .dac_hiz(dac_hiz),
    .pin_oe(pin_oe), .pin_out(pin_out), .cap_word(cap_word), .contention(contention)
  );

  task automatic chk(input string req, input string what, input logic [11:0] act,
                     input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [11:0] oe, input logic [11:0] o,
                         input logic [11:0] c, input logic [7:0] ct);
    chk(req, "pin_oe", pin_oe, oe);
    chk(req, "pin_out", pin_out, o);
    chk(req, "cap_word", cap_word, c);
    chk(req, "contention", {4'h0, contention}, {4'h0, ct});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk_all("R1", 12'h000, 12'h000, 12'h000, 8'h00); // R1 reset state
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      dir_wr  = VECS[i].dw;
      out_wr  = VECS[i].ow;
      cap_req = VECS[i].cq;
      wr_data = VECS[i].data;
      pin_in  = VECS[i].pins;
      dac_hiz = VECS[i].hiz;
      @(posedge clk);
      #1;
      chk_all(vec_req[i], VECS[i].e_oe, VECS[i].e_out, VECS[i].e_cap, VECS[i].e_cont);
    end
    // Directed: contention left active, then a mid-run reset (R1)
    @(negedge clk);
    dir_wr = 1'b0; out_wr = 1'b0; cap_req = 1'b0;
    dac_hiz = 8'h00;
    @(posedge clk);
    #1;
    chk("R8", "contention", {4'h0, contention}, 12'h0FF);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk_all("R1", 12'h000, 12'h000, 12'h000, 8'h00); // R1 mid-run reset
    @(negedge clk);
    rst = 1'b0;
    dac_hiz = 8'hFF;
    @(posedge clk);
    #1;
    chk("R1", "pin_oe after release", pin_oe, 12'h000); // direction cleared by R1
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule